// File: doc/BRIEF.md
# Partial Refresh Standby Controller

This block manages the low-power states of a self-refreshing dynamic memory. It turns two chip-enable inputs into one of three power states: active, normal standby and deep standby. It keeps a two-bit coverage code, written through a mode-register port, that sets how much of the array stays refreshed while the memory is in deep standby.

A refresh timer outside the block supplies a pulse for each refresh slot. On each pulse the block advances an internal refresh row counter. In the active state and in normal standby the counter sweeps every row. In deep standby it sweeps only a window that starts at row 0 and covers a half, a quarter or an eighth of the rows. With no coverage selected, the counter stops.

Leaving deep standby with no coverage means the array contents are lost. The block then raises a flag that says the memory must be re-initialized. Until a completed initialization handshake clears that flag, access requests are refused. The same flag is set at power-on reset. The coverage code holds no meaning after reset, so until the first mode-register write, deep standby behaves as if no coverage were selected.

Top module: `pr_standby_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (active), `refresh_row` is 0, `init_required` is 1 and `density_valid` is 0.
- R2: `pwr_state` follows the enables one clock later. With `cs2` high and `cs_n` low it is 0 (active). With `cs2` high and `cs_n` high it is 1 (normal standby).
- R3: Whenever `cs2` is low, `pwr_state` is 2 (deep standby) one clock later, whatever the level of `cs_n`.
- R4: A clock with `mr_we` high loads `mr_density` into `density_code` and sets `density_valid`; both are visible one clock later and keep their values until the next write. The codes are: 0 = half the rows, 1 = a quarter, 2 = an eighth, 3 = none.
- R5: Outside deep standby, each clock with `refresh_tick` high adds one to `refresh_row`, which wraps from ROWS-1 to 0. Without a tick the row holds.
- R6: In deep standby with code 0, 1 or 2, a tick moves `refresh_row` to 0 if the row plus one reaches ROWS/2, ROWS/4 or ROWS/8 respectively. Otherwise it adds one. A row left above the window is therefore sent back to 0 by the first tick.
- R7: In deep standby with no coverage, `refresh_row` holds on every tick and `refresh_on` is 0. In every other case `refresh_on` is 1.
- R8: A clock that takes `pwr_state` from 2 to any other state sets `init_required` if the coverage in force was none. An exit with any other coverage leaves the flag as it was.
- R9: A clock with `init_done` high clears `init_required`, unless the same clock sets it under R8. Setting wins.
- R10: `acc_grant` equals `acc_req` in the same cycle while `pwr_state` is 0 and `init_required` is 0. Otherwise it is 0.
- R11: While `density_valid` is 0, deep standby behaves as coverage code 3 for R6, R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Primary chip enable, active low |
| cs2 | input | 1 | Second chip enable; low selects deep standby |
| mr_we | input | 1 | Mode-register write strobe |
| mr_density | input | 2 | Coverage code to write |
| refresh_tick | input | 1 | One refresh slot from the external timer |
| init_done | input | 1 | Initialization handshake completed |
| acc_req | input | 1 | Access request |
| acc_grant | output | 1 | Access accepted this cycle |
| pwr_state | output | 2 | 0 active, 1 normal standby, 2 deep standby |
| refresh_row | output | ROW_W | Current refresh row |
| refresh_on | output | 1 | Refresh is running in the current state |
| init_required | output | 1 | Re-initialization must happen before access |
| density_valid | output | 1 | Coverage code has been written since reset |
| density_code | output | 2 | Stored coverage code |

## Verification
The power state, the stored code, the valid bit, the row counter and the re-initialization flag all sit one register behind their inputs. Each one is due on the first rising edge after the stimulus is applied. `acc_grant` and `refresh_on` are combinational from current inputs and registered state, so they are due in the same cycle. The bench drives inputs 1 ns after a rising edge and updates a behavioural model on that edge, using the input values that were stable across it. It compares every output on the falling edge, so the registered results are checked exactly one edge after their cause and the combinational results within the cycle. Directed checks at wrap points, on deep-standby exits and on a simultaneous set and clear of the flag name the rule each one covers.

// File: rtl/prsc_pkg.sv
package prsc_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_NORMAL = 2'd1,
        PS_DEEP   = 2'd2
    } pstate_e;

    localparam logic [1:0] COV_HALF    = 2'd0;
    localparam logic [1:0] COV_QUARTER = 2'd1;
    localparam logic [1:0] COV_EIGHTH  = 2'd2;
    localparam logic [1:0] COV_NONE    = 2'd3;

endpackage

// File: rtl/prsc_mode_reg.sv
module prsc_mode_reg
    import prsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mr_we,
    input  logic [1:0] mr_density,
    output logic [1:0] density_q,
    output logic       valid_q,
    output logic [1:0] eff_density
);

    typedef struct packed {
        logic [1:0] dens;
        logic       valid;
    } mr_t;

    mr_t mr_d, mr_q;

    always_comb begin
        mr_d = mr_q;
        if (mr_we) begin
            mr_d.dens  = mr_density;
            mr_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_q <= '{dens: COV_NONE, valid: 1'b0};
        end else begin
            mr_q <= mr_d;
        end
    end

    assign density_q   = mr_q.dens;
    assign valid_q     = mr_q.valid;
    // An unwritten code counts as no coverage.
    assign eff_density = mr_q.valid ? mr_q.dens : COV_NONE;

    // R4
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_we |=> (valid_q && density_q == $past(mr_density)));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_we |=> ($stable(density_q) && $stable(valid_q)));

endmodule

// File: rtl/prsc_state_track.sv
module prsc_state_track
    import prsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       cs2,
    input  logic       init_done,
    input  logic [1:0] eff_density,
    output pstate_e    pstate_q,
    output logic       init_req_q
);

    typedef struct packed {
        pstate_e st;
        logic    init_req;
    } trk_t;

    trk_t trk_d, trk_q;
    logic leaving_deep;

    always_comb begin
        trk_d = trk_q;
        if (!cs2) begin
            trk_d.st = PS_DEEP;
        end else if (cs_n) begin
            trk_d.st = PS_NORMAL;
        end else begin
            trk_d.st = PS_ACTIVE;
        end

        leaving_deep = (trk_q.st == PS_DEEP) && (trk_d.st != PS_DEEP);

        // A set caused by a lossy exit has priority over a clear.
        if (leaving_deep && (eff_density == COV_NONE)) begin
            trk_d.init_req = 1'b1;
        end else if (init_done) begin
            trk_d.init_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{st: PS_ACTIVE, init_req: 1'b1};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pstate_q   = trk_q.st;
    assign init_req_q = trk_q.init_req;

    // R3
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs2 |=> (pstate_q == PS_DEEP));

    // R9
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_req_q) |-> $past(init_done));

    // R8
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_req_q) |-> ($past(pstate_q) == PS_DEEP && $past(eff_density) == COV_NONE));

endmodule

// File: rtl/prsc_row_counter.sv
module prsc_row_counter
    import prsc_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_tick,
    input  pstate_e          pstate,
    input  logic [1:0]       eff_density,
    output logic [ROW_W-1:0] row_q,
    output logic             refresh_on
);

    localparam logic [ROW_W:0] ROW_ONE  = (ROW_W+1)'(1);
    localparam logic [ROW_W:0] LIM_HALF = ROW_ONE << (ROW_W - 1);
    localparam logic [ROW_W:0] LIM_QTR  = ROW_ONE << (ROW_W - 2);
    localparam logic [ROW_W:0] LIM_EGH  = ROW_ONE << (ROW_W - 3);

    typedef struct packed {
        logic [ROW_W-1:0] row;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [ROW_W:0] win_lim;
    logic [ROW_W:0] row_plus;
    logic           in_deep;
    logic           stopped;

    always_comb begin
        unique case (eff_density)
            COV_HALF:    win_lim = LIM_HALF;
            COV_QUARTER: win_lim = LIM_QTR;
            COV_EIGHTH:  win_lim = LIM_EGH;
            default:     win_lim = '0;
        endcase
    end

    assign in_deep    = (pstate == PS_DEEP);
    assign stopped    = in_deep && (eff_density == COV_NONE);
    assign row_plus   = {1'b0, cnt_q.row} + ROW_ONE;
    assign refresh_on = !stopped;

    always_comb begin
        cnt_d = cnt_q;
        if (refresh_tick && !stopped) begin
            if (in_deep && (row_plus >= win_lim)) begin
                cnt_d.row = '0;
            end else begin
                cnt_d.row = row_plus[ROW_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{row: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign row_q = cnt_q.row;

    // R5
    row_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_tick |=> $stable(row_q));

    // R7
    row_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_DEEP && eff_density == COV_NONE) |=> $stable(row_q));

    // R6
    row_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_deep && eff_density != COV_NONE && refresh_tick) |=>
            ({1'b0, row_q} < $past(win_lim)));

endmodule

// File: rtl/pr_standby_ctrl.sv
module pr_standby_ctrl
    import prsc_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs2,
    input  logic             mr_we,
    input  logic [1:0]       mr_density,
    input  logic             refresh_tick,
    input  logic             init_done,
    input  logic             acc_req,
    output logic             acc_grant,
    output logic [1:0]       pwr_state,
    output logic [ROW_W-1:0] refresh_row,
    output logic             refresh_on,
    output logic             init_required,
    output logic             density_valid,
    output logic [1:0]       density_code
);

    logic [1:0] eff_density;
    pstate_e    pstate;
    logic       init_req;

    prsc_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mr_we       (mr_we),
        .mr_density  (mr_density),
        .density_q   (density_code),
        .valid_q     (density_valid),
        .eff_density (eff_density)
    );

    prsc_state_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .cs2         (cs2),
        .init_done   (init_done),
        .eff_density (eff_density),
        .pstate_q    (pstate),
        .init_req_q  (init_req)
    );

    prsc_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_tick (refresh_tick),
        .pstate       (pstate),
        .eff_density  (eff_density),
        .row_q        (refresh_row),
        .refresh_on   (refresh_on)
    );

    assign pwr_state     = pstate;
    assign init_required = init_req;
    assign acc_grant     = acc_req && (pstate == PS_ACTIVE) && !init_req;

    // R10
    grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_required) && $past(!init_done)) |-> !acc_grant);

endmodule

// File: tb/pr_standby_ctrl_tb_top.sv
module pr_standby_ctrl_tb_top;

    localparam int ROW_W = 6;
    localparam int ROWS  = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, cs2 = 1'b1, mr_we = 1'b0, refresh_tick = 1'b0;
    logic init_done = 1'b0, acc_req = 1'b0;
    logic [1:0] mr_density = 2'd0;
    logic acc_grant, refresh_on, init_required, density_valid;
    logic [1:0] pwr_state, density_code;
    logic [ROW_W-1:0] refresh_row;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Reference model state
    int m_st = 0, m_row = 0, m_init = 1, m_valid = 0, m_dens = 3;

    always #2 clk = ~clk;

    pr_standby_ctrl #(.ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs2(cs2), .mr_we(mr_we),
        .mr_density(mr_density), .refresh_tick(refresh_tick), .init_done(init_done),
        .acc_req(acc_req), .acc_grant(acc_grant), .pwr_state(pwr_state),
        .refresh_row(refresh_row), .refresh_on(refresh_on),
        .init_required(init_required), .density_valid(density_valid),
        .density_code(density_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_cov();
        return m_valid ? m_dens : 3;
    endfunction

    // Behavioural model, advanced on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_row = 0; m_init = 1; m_valid = 0; m_dens = 3;
        end else begin
            int nst, nrow, ninit, cov, lim;
            cov  = eff_cov();
            nst  = !cs2 ? 2 : (cs_n ? 1 : 0);
            nrow = m_row;
            if (refresh_tick) begin
                if (m_st != 2) nrow = (m_row + 1) % ROWS;
                else if (cov != 3) begin
                    lim  = ROWS / (2 << cov);
                    nrow = (m_row + 1 >= lim) ? 0 : m_row + 1;
                end
            end
            ninit = m_init;
            if (m_st == 2 && nst != 2 && cov == 3) ninit = 1;
            else if (init_done) ninit = 0;
            if (mr_we) begin m_valid = 1; m_dens = mr_density; end
            m_st = nst; m_row = nrow; m_init = ninit;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_st == 2 ? "R3" : "R2", pwr_state, m_st);
            chk(m_st != 2 ? "R5" : (eff_cov() == 3 ? "R7" : "R6"), refresh_row, m_row);
            chk("R7", refresh_on, !(m_st == 2 && eff_cov() == 3));
            chk("R8", init_required, m_init);
            chk("R4", density_valid, m_valid);
            if (m_valid) chk("R4", density_code, m_dens);
            chk("R10", acc_grant, acc_req && m_st == 0 && !m_init);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int k);
        refresh_tick = 1'b1;
        repeat (k) cyc();
        refresh_tick = 1'b0;
    endtask

    task automatic pulse_init();
        init_done = 1'b1; cyc(); init_done = 1'b0;
    endtask

    task automatic write_cov(input logic [1:0] c);
        mr_density = c; mr_we = 1'b1; cyc(); mr_we = 1'b0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", pwr_state, 0);
        chk("R1", refresh_row, 0);
        chk("R1", init_required, 1);
        chk("R1", density_valid, 0);

        cyc();
        acc_req = 1'b1; cyc();
        @(negedge clk); chk("R10", acc_grant, 0);
        cyc();
        pulse_init();
        @(negedge clk);
        chk("R9", init_required, 0);
        chk("R10", acc_grant, 1);
        cyc(); acc_req = 1'b0;

        // R5 full-range wrap
        ticks(70);
        @(negedge clk); chk("R5", refresh_row, 70 % ROWS);
        cyc();

        // R2 normal standby
        cs_n = 1'b1; acc_req = 1'b1; cyc();
        @(negedge clk);
        chk("R2", pwr_state, 1);
        chk("R10", acc_grant, 0);
        cyc(); acc_req = 1'b0;
        ticks(3);

        // R11 deep standby before any write acts as no coverage
        cs2 = 1'b0; cyc();
        @(negedge clk);
        chk("R3", pwr_state, 2);
        chk("R11", refresh_on, 0);
        cyc(); ticks(5);
        @(negedge clk); chk("R11", refresh_row, 9);
        cyc();
        cs2 = 1'b1; cs_n = 1'b0; cyc();
        @(negedge clk); chk("R11", init_required, 1);
        cyc(); pulse_init();

        // every coverage code, with an exit from deep standby for each
        for (int d = 0; d < 4; d++) begin
            write_cov(2'(d));
            @(negedge clk);
            chk("R4", density_valid, 1);
            chk("R4", density_code, d);
            cyc();
            ticks(5 + d);
            cs_n = d[0]; cs2 = 1'b0; cyc();
            ticks(40);
            if (d == 3) begin
                // R9 set and clear in the same cycle: set wins
                cs2 = 1'b1; cs_n = 1'b0; init_done = 1'b1; cyc(); init_done = 1'b0;
                @(negedge clk); chk("R9", init_required, 1);
                cyc(); pulse_init();
            end else begin
                cs2 = 1'b1; cs_n = 1'b0; cyc();
                @(negedge clk); chk("R8", init_required, 0);
                cyc();
            end
        end

        // R6 row above the window returns to 0, then eighth wrap
        write_cov(2'd2);
        while (refresh_row != 6'd40) ticks(1);
        cs2 = 1'b0; cyc();
        ticks(1);
        @(negedge clk); chk("R6", refresh_row, 0);
        cyc(); ticks(ROWS / 8 - 1);
        @(negedge clk); chk("R6", refresh_row, ROWS / 8 - 1);
        cyc(); ticks(1);
        @(negedge clk); chk("R6", refresh_row, 0);
        cyc();

        // R4 code change while in deep standby: half window
        write_cov(2'd0);
        ticks(ROWS / 2);
        @(negedge clk); chk("R6", refresh_row, 0);
        cyc();
        // R3 deep standby with cs_n high as well
        cs_n = 1'b1; cyc();
        @(negedge clk); chk("R3", pwr_state, 2);
        cyc();
        write_cov(2'd3); ticks(4);
        @(negedge clk); chk("R7", refresh_row, 0);
        cyc();
        cs2 = 1'b1; cyc();
        @(negedge clk); chk("R8", init_required, 1);
        cyc(); cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule